// File: doc/BRIEF.md
# Low-Power Partitioned Scan Sequencer

This controller runs test application for a full-scan circuit whose scan cells are split into K partitioned chains plus one extra chain. One serial scan-in line reaches every chain. The sequencer picks which chain may shift by driving a single clock-enable bit from a rotating one-hot register. The chains therefore shift one after another, never together. While a partitioned chain shifts, the primary inputs of the circuit are driven with that chain's own holding vector. This vector blocks switching in the combinational logic fed by the chain.

For every pattern the partitioned chains shift in order 0, 1, ..., K-1. Each is preceded by one idle cycle in which the primary-input multiplexer settles on the new holding vector. The extra chain has no holding vector, so it shifts next with the functional input part of the pattern applied. A single capture cycle then loads the response. This loop repeats for the requested number of patterns, after which a done flag is raised. The holding vectors and all chain lengths, including the extra chain's, are written through a small write port before the start pulse. The scan-out line is multiplexed from whichever chain is shifting.

Top module: `scan_seq_top`

## Requirements
- R1: While reset is held and just after it, no shift or capture enable is active, `done` is 0 and `pi_out` equals `func_pi`.
- R2: At most one of the `chain_se` bits, `extra_se` and `capture_en` is 1 in any cycle.
- R3: Within a pattern, partitioned chain j (bit j of `chain_se`) is enabled for exactly its written length in consecutive cycles, and the chains are served in the order 0 to K-1.
- R4: Each partitioned chain's shift is preceded by exactly one cycle with no enable active. In that cycle and in all of the chain's shift cycles, `pi_out` equals the holding vector written for that chain.
- R5: After chain K-1, if the extra chain length (length index K) is non-zero, one idle cycle follows. Then `extra_se` is 1 for exactly that length. `pi_out` equals `func_pi` throughout.
- R6: If the extra chain length is zero, `capture_en` is asserted in the cycle right after the last shift of chain K-1, with no idle cycle and no `extra_se`.
- R7: Each pattern ends with exactly one `capture_en` cycle with `pi_out` equal to `func_pi`. The whole sequence runs `pat_count` times.
- R8: `done` rises in the cycle after the final capture and stays at 1 until the next start. Meanwhile `pi_out` equals `func_pi`.
- R9: While a chain shifts, `scan_out` equals that chain's bit of `chain_so`, with bit K belonging to the extra chain.
- R10: A start with `pat_count` of 0 sets `done` in the next cycle and activates no enable.
- R11: A partitioned chain whose written length is 0 gets its idle cycle, holding its vector, but no shift cycle.
- R12: A start pulse given while `done` is 1 begins a new run from chain 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hv_we | input | 1 | Holding-vector write strobe |
| hv_idx | input | IDX_W | Chain number for holding-vector write (0..K-1) |
| hv_data | input | PI_W | Holding vector to write |
| len_we | input | 1 | Chain-length write strobe |
| len_idx | input | IDX_W | Chain number for length write, K selects the extra chain |
| len_data | input | LEN_W | Chain length to write |
| start | input | 1 | Begin a run (accepted when idle or done) |
| pat_count | input | PAT_W | Number of patterns in the run |
| func_pi | input | PI_W | Functional input part of the current pattern |
| chain_so | input | K+1 | Serial outputs of all chains, bit K is the extra chain |
| chain_se | output | K | One-hot shift enables of the partitioned chains |
| extra_se | output | 1 | Shift enable of the extra chain |
| capture_en | output | 1 | Capture clock enable |
| pi_out | output | PI_W | Value driven onto the circuit's primary inputs |
| scan_out | output | 1 | Serial scan-out from the selected chain |
| done | output | 1 | Run finished |

## Verification
Two events can land on the same cycle boundary. One is the end of the last partitioned chain's shift. The other is the entry into capture, which happens when the extra chain length is zero. With no idle cycle between them, an off-by-one in the down-counter or the phase decision would either overlap the two enables or insert a stray cycle. The bench writes an extra length of zero and requires `capture_en` in the cycle directly after the final `chain_se` cycle. The checker's exclusivity property rejects any overlap. A second coincidence is a start pulse arriving while `done` is high, which must restart cleanly at chain 0.

// File: rtl/scan_seq_pkg.sv
`timescale 1ns/1ps
package scan_seq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_GAP,
        PH_SHIFT,
        PH_XGAP,
        PH_XSHIFT,
        PH_CAPTURE,
        PH_DONE
    } phase_e;

    typedef struct packed {
        logic shift_part;
        logic shift_extra;
        logic capture;
        logic finished;
        logic hold_sel;
    } seq_ctl_t;

    function automatic logic [7:0] oh_index(input logic [31:0] oh);
        logic [7:0] r;
        r = '0;
        for (int i = 0; i < 32; i++) begin
            if (oh[i]) r = 8'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/scan_cfg_bank.sv
`timescale 1ns/1ps
module scan_cfg_bank #(
    parameter int K     = 3,
    parameter int PI_W  = 8,
    parameter int LEN_W = 6,
    localparam int IDX_W = $clog2(K + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hv_we,
    input  logic [IDX_W-1:0] hv_idx,
    input  logic [PI_W-1:0]  hv_data,
    input  logic             len_we,
    input  logic [IDX_W-1:0] len_idx,
    input  logic [LEN_W-1:0] len_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [PI_W-1:0]  hv_rd,
    output logic [LEN_W-1:0] len_rd,
    output logic [LEN_W-1:0] xlen
);

    logic [PI_W-1:0]  hv_q  [K];
    logic [LEN_W-1:0] len_q [K+1];

    for (genvar g = 0; g < K; g++) begin : g_hv
        always_ff @(posedge clk) begin
            if (rst) hv_q[g] <= '0;
            else if (hv_we && hv_idx == IDX_W'(g)) hv_q[g] <= hv_data;
        end
    end

    for (genvar g = 0; g <= K; g++) begin : g_len
        always_ff @(posedge clk) begin
            if (rst) len_q[g] <= '0;
            else if (len_we && len_idx == IDX_W'(g)) len_q[g] <= len_data;
        end
    end

    always_comb begin
        hv_rd  = '0;
        len_rd = '0;
        for (int i = 0; i < K; i++) begin
            if (rd_idx == IDX_W'(i)) begin
                hv_rd  = hv_q[i];
                len_rd = len_q[i];
            end
        end
    end

    assign xlen = len_q[K];

endmodule

// File: rtl/scan_chain_ring.sv
`timescale 1ns/1ps
module scan_chain_ring #(
    parameter int K = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         advance,
    output logic [K-1:0] sel_oh
);

    localparam logic [K-1:0] FIRST = K'(1);

    always_ff @(posedge clk) begin
        if (rst || load) sel_oh <= FIRST;
        else if (advance) sel_oh <= {sel_oh[K-2:0], sel_oh[K-1]};
    end

endmodule

// File: rtl/scan_phase_fsm.sv
`timescale 1ns/1ps
module scan_phase_fsm
    import scan_seq_pkg::*;
#(
    parameter int LEN_W = 6,
    parameter int PAT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [PAT_W-1:0] pat_count,
    input  logic [LEN_W-1:0] cur_len,
    input  logic [LEN_W-1:0] xlen,
    input  logic             sel_last,
    output logic             ring_load,
    output logic             ring_adv,
    output seq_ctl_t         ctl
);

    phase_e           ph, ph_nx;
    logic [LEN_W-1:0] cnt, cnt_nx;
    logic [PAT_W-1:0] pats_left, pats_nx;

    always_comb begin
        ph_nx     = ph;
        cnt_nx    = cnt;
        pats_nx   = pats_left;
        ring_load = 1'b0;
        ring_adv  = 1'b0;
        unique case (ph)
            PH_IDLE, PH_DONE: begin
                if (start) begin
                    pats_nx   = pat_count;
                    ring_load = 1'b1;
                    ph_nx     = (pat_count == '0) ? PH_DONE : PH_GAP;
                end
            end
            PH_GAP: begin
                if (cur_len != '0) begin
                    cnt_nx = cur_len - 1'b1;
                    ph_nx  = PH_SHIFT;
                end else if (sel_last) begin
                    ph_nx = (xlen == '0) ? PH_CAPTURE : PH_XGAP;
                end else begin
                    ring_adv = 1'b1;
                    ph_nx    = PH_GAP;
                end
            end
            PH_SHIFT: begin
                if (cnt != '0) begin
                    cnt_nx = cnt - 1'b1;
                end else if (sel_last) begin
                    ph_nx = (xlen == '0) ? PH_CAPTURE : PH_XGAP;
                end else begin
                    ring_adv = 1'b1;
                    ph_nx    = PH_GAP;
                end
            end
            PH_XGAP: begin
                cnt_nx = xlen - 1'b1;
                ph_nx  = PH_XSHIFT;
            end
            PH_XSHIFT: begin
                if (cnt != '0) cnt_nx = cnt - 1'b1;
                else ph_nx = PH_CAPTURE;
            end
            PH_CAPTURE: begin
                pats_nx = pats_left - 1'b1;
                if (pats_left == PAT_W'(1)) begin
                    ph_nx = PH_DONE;
                end else begin
                    ring_load = 1'b1;
                    ph_nx     = PH_GAP;
                end
            end
            default: ph_nx = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph        <= PH_IDLE;
            cnt       <= '0;
            pats_left <= '0;
        end else begin
            ph        <= ph_nx;
            cnt       <= cnt_nx;
            pats_left <= pats_nx;
        end
    end

    always_comb begin
        ctl.shift_part  = (ph == PH_SHIFT);
        ctl.shift_extra = (ph == PH_XSHIFT);
        ctl.capture     = (ph == PH_CAPTURE);
        ctl.finished    = (ph == PH_DONE);
        ctl.hold_sel    = (ph == PH_GAP) || (ph == PH_SHIFT);
    end

endmodule

// File: rtl/scan_seq_top.sv
`timescale 1ns/1ps
module scan_seq_top
    import scan_seq_pkg::*;
#(
    parameter int K     = 3,
    parameter int PI_W  = 8,
    parameter int LEN_W = 6,
    parameter int PAT_W = 6,
    localparam int IDX_W = $clog2(K + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hv_we,
    input  logic [IDX_W-1:0] hv_idx,
    input  logic [PI_W-1:0]  hv_data,
    input  logic             len_we,
    input  logic [IDX_W-1:0] len_idx,
    input  logic [LEN_W-1:0] len_data,
    input  logic             start,
    input  logic [PAT_W-1:0] pat_count,
    input  logic [PI_W-1:0]  func_pi,
    input  logic [K:0]       chain_so,
    output logic [K-1:0]     chain_se,
    output logic             extra_se,
    output logic             capture_en,
    output logic [PI_W-1:0]  pi_out,
    output logic             scan_out,
    output logic             done
);

    logic [K-1:0]     sel_oh;
    logic [7:0]       idx_full;
    logic [IDX_W-1:0] cur_idx;
    logic [PI_W-1:0]  hv_rd;
    logic [LEN_W-1:0] len_rd, xlen;
    logic             ring_load, ring_adv;
    seq_ctl_t         ctl;

    assign idx_full = oh_index(32'(sel_oh));
    assign cur_idx  = idx_full[IDX_W-1:0];

    scan_cfg_bank #(.K(K), .PI_W(PI_W), .LEN_W(LEN_W)) u_bank (
        .clk(clk), .rst(rst),
        .hv_we(hv_we), .hv_idx(hv_idx), .hv_data(hv_data),
        .len_we(len_we), .len_idx(len_idx), .len_data(len_data),
        .rd_idx(cur_idx), .hv_rd(hv_rd), .len_rd(len_rd), .xlen(xlen)
    );

    scan_chain_ring #(.K(K)) u_ring (
        .clk(clk), .rst(rst), .load(ring_load), .advance(ring_adv),
        .sel_oh(sel_oh)
    );

    scan_phase_fsm #(.LEN_W(LEN_W), .PAT_W(PAT_W)) u_fsm (
        .clk(clk), .rst(rst), .start(start), .pat_count(pat_count),
        .cur_len(len_rd), .xlen(xlen), .sel_last(sel_oh[K-1]),
        .ring_load(ring_load), .ring_adv(ring_adv), .ctl(ctl)
    );

    assign chain_se   = ctl.shift_part ? sel_oh : '0;
    assign extra_se   = ctl.shift_extra;
    assign capture_en = ctl.capture;
    assign done       = ctl.finished;
    assign pi_out     = ctl.hold_sel ? hv_rd : func_pi;
    assign scan_out   = ctl.shift_extra ? chain_so[K] : chain_so[cur_idx];

endmodule

// File: rtl/scan_seq_checks.sv
`timescale 1ns/1ps
module scan_seq_checks #(
    parameter int K    = 3,
    parameter int PI_W = 8
) (
    input logic            clk,
    input logic            rst,
    input logic            start,
    input logic [K:0]      chain_so,
    input logic [K-1:0]    chain_se,
    input logic            extra_se,
    input logic            capture_en,
    input logic [PI_W-1:0] pi_out,
    input logic            scan_out,
    input logic            done
);

    assert_one_enable_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0({chain_se, extra_se, capture_en}));

    assert_gap_before_chain_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(|chain_se) |-> $past({chain_se, extra_se, capture_en}) == '0);

    assert_hold_stable_R4: assert property (@(posedge clk) disable iff (rst)
        ((|chain_se) && $past(chain_se) == chain_se) |-> $stable(pi_out));

    assert_extra_gap_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(extra_se) |-> $past({chain_se, capture_en}) == '0);

    assert_single_capture_R7: assert property (@(posedge clk) disable iff (rst)
        capture_en |=> !capture_en);

    assert_done_cause_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> ($past(capture_en) || $past(start)));

    assert_extra_out_R9: assert property (@(posedge clk) disable iff (rst)
        extra_se |-> scan_out == chain_so[K]);

endmodule

bind scan_seq_top scan_seq_checks #(.K(K), .PI_W(PI_W)) u_chk (
    .clk(clk), .rst(rst), .start(start), .chain_so(chain_so),
    .chain_se(chain_se), .extra_se(extra_se), .capture_en(capture_en),
    .pi_out(pi_out), .scan_out(scan_out), .done(done)
);

// File: tb/sim_scan_seq_top.sv
`timescale 1ns/1ps
module sim_scan_seq_top;

    localparam int K     = 3;
    localparam int PI_W  = 8;
    localparam int LEN_W = 6;
    localparam int PAT_W = 6;
    localparam int IDX_W = $clog2(K + 1);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             hv_we = 1'b0;
    logic [IDX_W-1:0] hv_idx = '0;
    logic [PI_W-1:0]  hv_data = '0;
    logic             len_we = 1'b0;
    logic [IDX_W-1:0] len_idx = '0;
    logic [LEN_W-1:0] len_data = '0;
    logic             start = 1'b0;
    logic [PAT_W-1:0] pat_count = '0;
    logic [PI_W-1:0]  func_pi = 8'hC3;
    logic [K:0]       chain_so = '0;
    logic [K-1:0]     chain_se;
    logic             extra_se, capture_en, scan_out, done;
    logic [PI_W-1:0]  pi_out;

    int checks = 0;
    int failures = 0;

    logic [PI_W-1:0]  m_hv  [K];
    logic [LEN_W-1:0] m_len [K+1];

    always #4 clk = ~clk;

    scan_seq_top #(.K(K), .PI_W(PI_W), .LEN_W(LEN_W), .PAT_W(PAT_W)) u0 (
        .clk(clk), .rst(rst), .hv_we(hv_we), .hv_idx(hv_idx), .hv_data(hv_data),
        .len_we(len_we), .len_idx(len_idx), .len_data(len_data),
        .start(start), .pat_count(pat_count), .func_pi(func_pi),
        .chain_so(chain_so), .chain_se(chain_se), .extra_se(extra_se),
        .capture_en(capture_en), .pi_out(pi_out), .scan_out(scan_out), .done(done)
    );

    task automatic wr_hv(input int idx, input logic [PI_W-1:0] v);
        hv_we = 1'b1; hv_idx = IDX_W'(idx); hv_data = v; m_hv[idx] = v;
        @(negedge clk);
        hv_we = 1'b0;
    endtask

    task automatic wr_len(input int idx, input logic [LEN_W-1:0] v);
        len_we = 1'b1; len_idx = IDX_W'(idx); len_data = v; m_len[idx] = v;
        @(negedge clk);
        len_we = 1'b0;
    endtask

    // Called at a negedge; checks this cycle's outputs, then moves to the next negedge.
    task automatic exp_cycle(input logic [K-1:0] e_se, input logic e_x, input logic e_cap,
                             input logic e_done, input logic [PI_W-1:0] e_pi, input string req);
        logic [31:0] r;
        logic [K:0]  so;
        logic        e_so;
        r = $urandom;
        so = r[K:0];
        chain_so = so;
        #1;
        checks++;
        if ({chain_se, extra_se, capture_en, done, pi_out} !== {e_se, e_x, e_cap, e_done, e_pi}) begin
            failures++;
            $display("FAIL %s: actual se=%b x=%b cap=%b done=%b pi=%h expected se=%b x=%b cap=%b done=%b pi=%h",
                     req, chain_se, extra_se, capture_en, done, pi_out, e_se, e_x, e_cap, e_done, e_pi);
        end
        if (e_x || (|e_se)) begin
            e_so = so[K];
            for (int i = 0; i < K; i++) if (e_se[i]) e_so = so[i];
            checks++;
            if (scan_out !== e_so) begin
                failures++;
                $display("FAIL R9: actual scan_out=%b expected %b", scan_out, e_so);
            end
        end
        @(negedge clk);
    endtask

    // Model of the full run, built from the requirements.
    task automatic run_set(input int n, input string tag);
        start = 1'b1; pat_count = PAT_W'(n);
        @(negedge clk);
        start = 1'b0;
        if (n == 0) begin
            exp_cycle('0, 1'b0, 1'b0, 1'b1, func_pi, {tag, " R10"});
        end else begin
            for (int p = 0; p < n; p++) begin
                for (int j = 0; j < K; j++) begin
                    exp_cycle('0, 1'b0, 1'b0, 1'b0, m_hv[j],
                              (m_len[j] == 0) ? {tag, " R11"} : {tag, " R4"});
                    for (int c = 0; c < int'(m_len[j]); c++)
                        exp_cycle(K'(1) << j, 1'b0, 1'b0, 1'b0, m_hv[j], {tag, " R3"});
                end
                if (m_len[K] != 0) begin
                    exp_cycle('0, 1'b0, 1'b0, 1'b0, func_pi, {tag, " R5"});
                    for (int c = 0; c < int'(m_len[K]); c++)
                        exp_cycle('0, 1'b1, 1'b0, 1'b0, func_pi, {tag, " R5"});
                    exp_cycle('0, 1'b0, 1'b1, 1'b0, func_pi, {tag, " R7"});
                end else begin
                    exp_cycle('0, 1'b0, 1'b1, 1'b0, func_pi, {tag, " R6"});
                end
            end
            exp_cycle('0, 1'b0, 1'b0, 1'b1, func_pi, {tag, " R8"});
        end
        exp_cycle('0, 1'b0, 1'b0, 1'b1, func_pi, {tag, " R8"});
    endtask

    task automatic t_reset();
        @(negedge clk);
        exp_cycle('0, 1'b0, 1'b0, 1'b0, func_pi, "R1 in reset");
        rst = 1'b0;
        exp_cycle('0, 1'b0, 1'b0, 1'b0, func_pi, "R1 after reset");
    endtask

    task automatic t_basic();
        wr_hv(0, 8'h11); wr_hv(1, 8'h22); wr_hv(2, 8'h44);
        wr_len(0, 3); wr_len(1, 2); wr_len(2, 4); wr_len(K, 3);
        run_set(2, "basic");
    endtask

    task automatic t_no_extra();
        wr_len(K, 0);
        func_pi = 8'h5A;
        run_set(1, "noextra");
    endtask

    task automatic t_zero_part();
        wr_len(1, 0); wr_len(K, 2);
        run_set(1, "zeropart");
    endtask

    task automatic t_zero_count();
        run_set(0, "zerocount");
    endtask

    task automatic t_restart();
        wr_len(1, 1);
        func_pi = 8'h96;
        run_set(3, "restart R12");
    endtask

    initial begin
        for (int i = 0; i < K; i++) m_hv[i] = '0;
        for (int i = 0; i <= K; i++) m_len[i] = '0;
        t_reset();
        t_basic();
        t_no_extra();
        t_zero_part();
        t_zero_count();
        t_restart();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(8 * 100000);
        checks++;
        failures++;
        $display("FAIL watchdog: actual run still going expected finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule